// File: doc/BRIEF.md
# Exception Syndrome Register

This block is the 32-bit status register that a processor core reads to learn why its most recent exception was taken. The exception logic raises event strobes for six causes: instruction machine check, illegal instruction, privileged instruction, trap, data-storage and instruction-storage. Qualifier inputs give more detail about the cause: a store access, a zone-protection violation, a non-executable or guarded fetch, and a U0-protection violation. On the clock edge where any strobe is high, the register is loaded with a fresh image of the cause. All other bits are cleared.

The only exception to that overwrite is the instruction machine-check flag. While the machine-state enable for machine checks is low, a set flag survives every later exception, including one that arrives in the same cycle as the machine check. Software can load the register through a special-register write port. Reserved and unsupported bit positions are forced to zero on that path. The current contents are always visible on the read port.

Top module: `exc_syndrome_reg`

## Requirements
- R1: A synchronous active-high reset clears the whole register to 0x0000_0000.
- R2: Field n, counting from the most significant end, sits at vector index 31-n. The instruction machine-check flag is field 0 (mask 0x8000_0000). Illegal is field 4 (0x0800_0000), privileged is field 5 (0x0400_0000) and trap is field 6 (0x0200_0000). Each of these is set by its own strobe.
- R3: On the edge where any event strobe is high, every bit not produced by that event is cleared, subject only to R7.
- R4: The store flag (field 8, 0x0080_0000) is set only by a data-storage event with the store qualifier high.
- R5: The zone flag (field 9, 0x0040_0000) is set by a data-storage or instruction-storage event with the zone qualifier high. For an instruction-storage event it is cleared when the non-executable/guarded qualifier is high.
- R6: The U0 flag (field 16, 0x0000_8000) is set only by a data-storage event with the U0 qualifier high. The qualifier has no effect on other events.
- R7: With machine-check enable at 0, an already set machine-check flag stays set when any exception updates the register.
- R8: A machine check and another event raised in the same cycle with the enable at 0 both record their flags.
- R9: With machine-check enable at 1, an exception that is not a machine check clears the machine-check flag.
- R10: A software write loads the write data ANDed with 0x8EC0_8000. This forces reserved fields and unsupported fields 7, 12 and 13 to 0. A software write never keeps the old machine-check flag.
- R11: If a software write and an event occur in the same cycle, the event update is applied and the write data is discarded.
- R12: With no event and no write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_mchk | input | 1 | Instruction machine-check event |
| evt_illegal | input | 1 | Illegal-instruction event |
| evt_priv | input | 1 | Privileged-instruction event |
| evt_trap | input | 1 | Trap event |
| evt_dstore | input | 1 | Data-storage or data TLB-miss event |
| evt_istore | input | 1 | Instruction-storage event |
| q_store | input | 1 | Access was a store or store-like cache operation |
| q_zone | input | 1 | Cause was a zone-protection violation |
| q_nx_guard | input | 1 | Fetch from a non-executable or guarded address |
| q_u0 | input | 1 | Cause was a U0-protection violation |
| mchk_en | input | 1 | Machine-check enable from the machine state register |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Current register contents |

## Verification
The bench builds the block with the package's 32-bit width, which is the only width for which the field positions carry meaning. At that width one vector sequence can carry a machine-check flag across several later events while the enable is low, and then show it cleared once the enable is high. The same sequence covers a flag that was loaded by software and then kept, a write and an event that collide, and fully masked write data. Each qualifier is applied both with its matching event and with an event it must not affect.

// File: rtl/esr_pkg.sv
package esr_pkg;

    localparam int unsigned ESR_W = 32;

    // Field numbers count from the most significant end; the position matters
    // because the core's read path decodes these exact bits.
    typedef enum int unsigned {
        FLD_MCHK  = 0,
        FLD_ILL   = 4,
        FLD_PRIV  = 5,
        FLD_TRAP  = 6,
        FLD_STORE = 8,
        FLD_ZONE  = 9,
        FLD_U0    = 16
    } esr_field_e;

    typedef struct packed {
        logic mchk;
        logic ill;
        logic priv;
        logic trap;
        logic dstore;
        logic istore;
    } exc_strobe_t;

    typedef struct packed {
        logic store;
        logic zone;
        logic nx_guard;
        logic u0;
    } exc_qual_t;

    typedef struct packed {
        logic mchk;
        logic ill;
        logic priv;
        logic trap;
        logic store;
        logic zone;
        logic u0;
    } syn_flags_t;

    function automatic int unsigned fld_idx(esr_field_e f);
        return ESR_W - 1 - int'(f);
    endfunction

    function automatic logic [ESR_W-1:0] flags_to_word(syn_flags_t s);
        logic [ESR_W-1:0] w;
        w = '0;
        w[fld_idx(FLD_MCHK)]  = s.mchk;
        w[fld_idx(FLD_ILL)]   = s.ill;
        w[fld_idx(FLD_PRIV)]  = s.priv;
        w[fld_idx(FLD_TRAP)]  = s.trap;
        w[fld_idx(FLD_STORE)] = s.store;
        w[fld_idx(FLD_ZONE)]  = s.zone;
        w[fld_idx(FLD_U0)]    = s.u0;
        return w;
    endfunction

    localparam logic [ESR_W-1:0] LIVE_MASK = flags_to_word('1);
    localparam logic [ESR_W-1:0] MCHK_BIT  = flags_to_word(syn_flags_t'{mchk: 1'b1, default: 1'b0});

endpackage

// File: rtl/esr_event_decode.sv
module esr_event_decode
    import esr_pkg::*;
(
    input  exc_strobe_t stb,
    input  exc_qual_t   qual,
    output syn_flags_t  flags,
    output logic        taken
);
    always_comb begin
        flags.mchk  = stb.mchk;
        flags.ill   = stb.ill;
        flags.priv  = stb.priv;
        flags.trap  = stb.trap;
        flags.store = stb.dstore & qual.store;
        flags.zone  = qual.zone & (stb.dstore | (stb.istore & ~qual.nx_guard));
        flags.u0    = stb.dstore & qual.u0;
    end

    assign taken = |stb;
endmodule

// File: rtl/esr_write_filter.sv
module esr_write_filter
    import esr_pkg::*;
#(
    parameter int unsigned W = ESR_W
) (
    input  logic [W-1:0] wdata,
    output logic [W-1:0] wmasked
);
    // Per-bit gate: only implemented fields may be written.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE_MASK[i]) begin : g_live
            assign wmasked[i] = wdata[i];
        end else begin : g_dead
            assign wmasked[i] = 1'b0;
        end
    end
endmodule

// File: rtl/esr_next_state.sv
module esr_next_state
    import esr_pkg::*;
#(
    parameter int unsigned W = ESR_W
) (
    input  logic [W-1:0] cur,
    input  syn_flags_t   flags,
    input  logic         taken,
    input  logic         mchk_en,
    input  logic         we,
    input  logic [W-1:0] wmasked,
    output logic [W-1:0] nxt
);
    logic [W-1:0] image;
    logic [W-1:0] keep;

    always_comb begin
        image = flags_to_word(flags);
        keep  = mchk_en ? '0 : (cur & MCHK_BIT);
        if (taken)
            nxt = image | keep;
        else if (we)
            nxt = wmasked;
        else
            nxt = cur;
    end
endmodule

// File: rtl/exc_syndrome_reg.sv
module exc_syndrome_reg
    import esr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_mchk,
    input  logic             evt_illegal,
    input  logic             evt_priv,
    input  logic             evt_trap,
    input  logic             evt_dstore,
    input  logic             evt_istore,
    input  logic             q_store,
    input  logic             q_zone,
    input  logic             q_nx_guard,
    input  logic             q_u0,
    input  logic             mchk_en,
    input  logic             sw_we,
    input  logic [ESR_W-1:0] sw_wdata,
    output logic [ESR_W-1:0] rd_data
);
    exc_strobe_t      stb;
    exc_qual_t        qual;
    syn_flags_t       flags;
    logic             taken;
    logic [ESR_W-1:0] wmasked;
    logic [ESR_W-1:0] nxt;
    logic [ESR_W-1:0] esr_q;

    assign stb  = '{mchk: evt_mchk, ill: evt_illegal, priv: evt_priv,
                    trap: evt_trap, dstore: evt_dstore, istore: evt_istore};
    assign qual = '{store: q_store, zone: q_zone, nx_guard: q_nx_guard, u0: q_u0};

    esr_event_decode u_dec (
        .stb   (stb),
        .qual  (qual),
        .flags (flags),
        .taken (taken)
    );

    esr_write_filter #(.W(ESR_W)) u_wf (
        .wdata   (sw_wdata),
        .wmasked (wmasked)
    );

    esr_next_state #(.W(ESR_W)) u_ns (
        .cur     (esr_q),
        .flags   (flags),
        .taken   (taken),
        .mchk_en (mchk_en),
        .we      (sw_we),
        .wmasked (wmasked),
        .nxt     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            esr_q <= '0;
        else
            esr_q <= nxt;
    end

    assign rd_data = esr_q;
endmodule

// File: rtl/esr_checker.sv
module esr_checker
    import esr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             evt_mchk,
    input logic             evt_illegal,
    input logic             evt_priv,
    input logic             evt_trap,
    input logic             evt_dstore,
    input logic             evt_istore,
    input logic             mchk_en,
    input logic             sw_we,
    input logic [ESR_W-1:0] sw_wdata,
    input logic [ESR_W-1:0] rd_data
);
    logic any_evt;
    logic only_ill;
    assign any_evt  = evt_mchk | evt_illegal | evt_priv | evt_trap | evt_dstore | evt_istore;
    assign only_ill = evt_illegal & ~(evt_mchk | evt_priv | evt_trap | evt_dstore | evt_istore);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> rd_data == '0);

    p_dead_bits_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~LIVE_MASK) == '0);

    p_mchk_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        any_evt && !mchk_en && rd_data[ESR_W-1] |=> rd_data[ESR_W-1]);

    p_mchk_cleared_r9: assert property (@(posedge clk) disable iff (rst)
        any_evt && mchk_en && !evt_mchk |=> !rd_data[ESR_W-1]);

    p_write_load_r10: assert property (@(posedge clk) disable iff (rst)
        sw_we && !any_evt |=> rd_data == ($past(sw_wdata) & LIVE_MASK));

    p_event_wins_r11: assert property (@(posedge clk) disable iff (rst)
        sw_we && only_ill && mchk_en |=> rd_data == flags_to_word(syn_flags_t'{ill: 1'b1, default: 1'b0}));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !any_evt && !sw_we |=> $stable(rd_data));
endmodule

bind exc_syndrome_reg esr_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_mchk    (evt_mchk),
    .evt_illegal (evt_illegal),
    .evt_priv    (evt_priv),
    .evt_trap    (evt_trap),
    .evt_dstore  (evt_dstore),
    .evt_istore  (evt_istore),
    .mchk_en     (mchk_en),
    .sw_we       (sw_we),
    .sw_wdata    (sw_wdata),
    .rd_data     (rd_data)
);

// File: tb/tb_exc_syndrome_reg.sv
module tb_exc_syndrome_reg;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 18;

    typedef struct packed {
        logic [7:0]  req;
        logic        en;
        logic [5:0]  stb;   // {mchk, illegal, priv, trap, dstore, istore}
        logic [3:0]  q;     // {store, zone, nx_guard, u0}
        logic        we;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'd10, 1'b1, 6'b000000, 4'b0000, 1'b1, 32'hFFFF_FFFF, 32'h8EC0_8000}, // R10 masked write
        '{8'd3,  1'b1, 6'b010000, 4'b0000, 1'b0, 32'h0,         32'h0800_0000}, // R3 overwrite
        '{8'd2,  1'b0, 6'b100000, 4'b0000, 1'b0, 32'h0,         32'h8000_0000}, // R2 machine check
        '{8'd7,  1'b0, 6'b001000, 4'b0000, 1'b0, 32'h0,         32'h8400_0000}, // R7 kept
        '{8'd4,  1'b0, 6'b000010, 4'b1100, 1'b0, 32'h0,         32'h80C0_0000}, // R4 store+zone
        '{8'd5,  1'b0, 6'b000001, 4'b0110, 1'b0, 32'h0,         32'h8000_0000}, // R5 nx/guard clears
        '{8'd9,  1'b1, 6'b000100, 4'b0000, 1'b0, 32'h0,         32'h0200_0000}, // R9 cleared
        '{8'd6,  1'b1, 6'b000010, 4'b0001, 1'b0, 32'h0,         32'h0000_8000}, // R6 U0 flag
        '{8'd6,  1'b1, 6'b000001, 4'b1101, 1'b0, 32'h0,         32'h0040_0000}, // R6 U0 ignored on istore
        '{8'd8,  1'b0, 6'b100100, 4'b0000, 1'b0, 32'h0,         32'h8200_0000}, // R8 same cycle
        '{8'd10, 1'b0, 6'b000000, 4'b0000, 1'b1, 32'h0,         32'h0000_0000}, // R10 write not sticky
        '{8'd11, 1'b1, 6'b010000, 4'b0000, 1'b1, 32'h1234_5678, 32'h0800_0000}, // R11 event wins
        '{8'd12, 1'b1, 6'b000000, 4'b0000, 1'b0, 32'h0,         32'h0800_0000}, // R12 hold
        '{8'd10, 1'b1, 6'b000000, 4'b0000, 1'b1, 32'h810C_0000, 32'h8000_0000}, // R10 unsupported masked
        '{8'd7,  1'b0, 6'b010000, 4'b0000, 1'b0, 32'h0,         32'h8800_0000}, // R7 keeps written flag
        '{8'd9,  1'b1, 6'b100000, 4'b0000, 1'b0, 32'h0,         32'h8000_0000}, // R9 mchk enabled
        '{8'd9,  1'b1, 6'b010000, 4'b0000, 1'b0, 32'h0,         32'h0800_0000}, // R9 then cleared
        '{8'd4,  1'b1, 6'b000010, 4'b0000, 1'b0, 32'h0,         32'h0000_0000}  // R4 no qualifiers
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  stb = '0;
    logic [3:0]  q   = '0;
    logic        en  = 1'b1;
    logic        we  = 1'b0;
    logic [31:0] wd  = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_syndrome_reg dut (
        .clk         (clk),
        .rst         (rst),
        .evt_mchk    (stb[5]),
        .evt_illegal (stb[4]),
        .evt_priv    (stb[3]),
        .evt_trap    (stb[2]),
        .evt_dstore  (stb[1]),
        .evt_istore  (stb[0]),
        .q_store     (q[3]),
        .q_zone      (q[2]),
        .q_nx_guard  (q[1]),
        .q_u0        (q[0]),
        .mchk_en     (en),
        .sw_we       (we),
        .sw_wdata    (wd),
        .rd_data     (rd_data)
    );

    task automatic check(input int req, input logic [31:0] exp);
        n_checks++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL R%0d: rd_data=%08h expected=%08h", req, rd_data, exp);
        end
    endtask

    task automatic idle_inputs();
        stb = '0; q = '0; we = 1'b0; wd = '0; en = 1'b1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        @(negedge clk);
        check(1, 32'h0);                  // R1 reset state
        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            en  = VECS[i].en;
            stb = VECS[i].stb;
            q   = VECS[i].q;
            we  = VECS[i].we;
            wd  = VECS[i].wd;
            @(negedge clk);
            check(int'(VECS[i].req), VECS[i].exp);
        end
        // R12: several idle cycles keep the value
        idle_inputs();
        repeat (3) @(negedge clk);
        check(12, 32'h0000_0000);
        // R7 with data-storage, zone via dstore ignores nx_guard (R5)
        en = 1'b0; stb = 6'b100000;
        @(negedge clk);
        en = 1'b0; stb = 6'b000010; q = 4'b0110;
        @(negedge clk);
        check(5, 32'h8040_0000);
        // R1: reset mid-run clears a populated register
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule